// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block divides the system clock into time quanta and lays out the nominal bit time of a CAN receiver as one synchronisation quantum, a first phase segment and a second phase segment. Once in every bit time it decides a bit value from the receive line at the sample point. It then delivers that value with a one-cycle strobe at the end of the bit.

The timing setup has four fields: a prescaler, the two phase segment lengths and a triple-sampling mode bit. These are captured only while the software-initialisation input is high. While that input is high the bit timing is halted. When it goes low, a fresh bit begins. In triple mode the first phase segment grows by two quanta, and the bit value is the majority of three samples. The mode is disabled when the prescale divide is too small to space the samples. The received bit stream has no back-pressure, because a CAN bus cannot be paused. For that reason the output is a plain strobe with no ready signal, and a consumer must take each bit in the cycle its strobe is high.

Top module: `can_bit_sampler`

## Requirements
- R1: One time quantum lasts `cfg_prescale + 1` clock cycles, for every field value from 0 to 63.
- R2: For codes 1 to 7, the second phase segment lasts `cfg_ps2 + 1` quanta.
- R3: The first phase segment lasts `cfg_ps1 + 1` quanta. A bit time is 1 + first segment + second segment quanta, so the spacing between `bit_valid` pulses is that many quanta.
- R4: In single mode, the line is sampled once per bit, at the end of the last quantum of the first phase segment. `sample_pulse` is high for one cycle after that sample, exactly once per bit.
- R5: In triple mode, `rx_in` is sampled at the ends of the last three quanta of the first phase segment, and the decided bit is 1 when at least two of those samples are 1.
- R6: In triple mode, the first phase segment is two quanta longer than its code gives.
- R7: When `cfg_prescale` is below 3 (divide below 4), the triple mode bit is treated as 0. Timing and sampling are then those of single mode.
- R8: While `sw_init` is 0, changes on the configuration inputs have no effect on timing or sampling.
- R9: A second-segment code of 0 gives 2 quanta, and `ps2_err` is 1 for as long as that code is held. Otherwise `ps2_err` is 0.
- R10: `bit_valid` is high for one cycle, one clock after the last quantum of a bit ends, and `bit_value` then carries the bit decided in that bit. `bit_value` changes only in a cycle where `bit_valid` is 1.
- R11: After reset, `bit_valid`, `bit_value`, `sample_pulse` and `ps2_err` are 0, and the captured setup is a divide of 1, first segment code 0, second segment code 1 and single mode.
- R12: While `sw_init` is 1, no `bit_valid` or `sample_pulse` appears from the following cycle on. After `sw_init` falls, a new bit starts at its synchronisation quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_init | input | 1 | Software initialisation: captures the setup and halts timing |
| cfg_prescale | input | 6 | Prescaler field; divide is field + 1 |
| cfg_ps1 | input | 4 | First phase segment code |
| cfg_ps2 | input | 3 | Second phase segment code |
| cfg_triple | input | 1 | 1 selects three-sample majority mode |
| rx_in | input | 1 | Receive line, already synchronous to clk |
| bit_valid | output | 1 | One-cycle strobe at the end of each bit |
| bit_value | output | 1 | Decided bit value, updated with bit_valid |
| sample_pulse | output | 1 | One-cycle pulse after the sample point |
| ps2_err | output | 1 | Captured second segment code is 0 |

## Verification
The checks assume that `rx_in` and every configuration input are synchronous to `clk`, and that `sw_init` is held high for at least one full cycle, so the counters restart from a clean state. They also assume that the second segment never drops below two quanta. As a result, a sample pulse and the end-of-bit strobe can never fall in the same cycle. The stimulus changes all inputs only on the falling clock edge and drives `rx_in` with fresh random bits every cycle, so a single-sample decision and a majority decision differ often. Setup changes are made either inside an initialisation window or, on purpose, outside one to show that they are ignored.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  parameter int PRE_W = 6;
  parameter int PS1_W = 4;
  parameter int PS2_W = 3;
  parameter int TRIPLE_EXTRA = 2;

  // longest bit: sync + stretched segment 1 + longest segment 2
  localparam int BIT_MAX = 1 + (1 << PS1_W) + TRIPLE_EXTRA + (1 << PS2_W);
  localparam int QW      = $clog2(BIT_MAX + 1);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [PS1_W-1:0] ps1;
    logic [PS2_W-1:0] ps2;
    logic             triple;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int TRIPLE_MIN_BRP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_init,
  input  bt_cfg_t       cfg_in,
  output bt_cfg_t       cfg_q,
  output logic          triple_eff,
  output logic [QW-1:0] ps1_len,
  output logic [QW-1:0] bit_len,
  output logic          ps2_err
);
  localparam logic [PRE_W-1:0] TRIPLE_MIN_FIELD = PRE_W'(TRIPLE_MIN_BRP - 1);

  logic [QW-1:0] ps2_len;

  // setup is captured only inside the initialisation window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.pre    <= '0;
      cfg_q.ps1    <= '0;
      cfg_q.ps2    <= PS2_W'(1);
      cfg_q.triple <= 1'b0;
    end else if (sw_init) begin
      cfg_q <= cfg_in;
    end
  end

  always_comb begin
    triple_eff = cfg_q.triple && (cfg_q.pre >= TRIPLE_MIN_FIELD);
    ps1_len    = QW'(cfg_q.ps1) + QW'(1) + (triple_eff ? QW'(TRIPLE_EXTRA) : QW'(0));
    ps2_err    = (cfg_q.ps2 == '0);
    ps2_len    = ps2_err ? QW'(2) : QW'(cfg_q.ps2) + QW'(1);
    bit_len    = QW'(1) + ps1_len + ps2_len;
  end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] div_field,
  output logic         tq_tick
);
  logic [W-1:0] cnt;

  assign tq_tick = run && (cnt == div_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tq_tick)  cnt <= '0;
    else               cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/can_bt_segment.sv
module can_bt_segment
  import can_bt_pkg::*;
#(
  parameter int VOTES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tq_tick,
  input  logic [QW-1:0] ps1_len,
  input  logic [QW-1:0] bit_len,
  output logic          at_sample,
  output logic          at_presample,
  output logic          at_end
);
  logic [QW-1:0] quant;
  logic [VOTES-2:0] pre_hit;

  // quantum 0 is sync; the sample point closes quantum ps1_len
  generate
    for (genvar k = 0; k < VOTES - 1; k++) begin : g_pre
      assign pre_hit[k] = (quant == ps1_len - QW'(k + 1));
    end
  endgenerate

  assign at_sample    = tq_tick && (quant == ps1_len);
  assign at_presample = tq_tick && (|pre_hit);
  assign at_end       = tq_tick && (quant == bit_len - QW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       quant <= '0;
    else if (!run)    quant <= '0;
    else if (at_end)  quant <= '0;
    else if (tq_tick) quant <= quant + QW'(1);
  end
endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote #(
  parameter int VOTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic shift_en,
  input  logic multi,
  input  logic rx,
  output logic decided
);
  localparam int HW = VOTES - 1;

  logic [HW-1:0] hist;
  logic [VOTES-1:0] all_s;

  assign all_s   = {hist, rx};
  assign decided = multi ? ($countones(all_s) > (VOTES / 2)) : rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (!run)     hist <= '0;
    else if (shift_en) hist <= (HW > 1) ? {hist[HW-2:0], rx} : HW'(rx);
  end
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_bt_pkg::*;
#(
  parameter int TRIPLE_MIN_BRP = 4,
  parameter int VOTES          = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_init,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [PS1_W-1:0] cfg_ps1,
  input  logic [PS2_W-1:0] cfg_ps2,
  input  logic             cfg_triple,
  input  logic             rx_in,
  output logic             bit_valid,
  output logic             bit_value,
  output logic             sample_pulse,
  output logic             ps2_err
);
  bt_cfg_t       cfg_in;
  bt_cfg_t       cfg_q;
  logic          triple_eff;
  logic [QW-1:0] ps1_len;
  logic [QW-1:0] bit_len;
  logic          run;
  logic          tq_tick;
  logic          at_sample;
  logic          at_presample;
  logic          at_end;
  logic          decided;
  logic          held_bit;

  assign run    = !sw_init;
  assign cfg_in = '{pre: cfg_prescale, ps1: cfg_ps1, ps2: cfg_ps2, triple: cfg_triple};

  can_bt_cfg #(.TRIPLE_MIN_BRP(TRIPLE_MIN_BRP)) i_cfg (
    .clk(clk), .rst_n(rst_n), .sw_init(sw_init), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .triple_eff(triple_eff), .ps1_len(ps1_len),
    .bit_len(bit_len), .ps2_err(ps2_err)
  );

  can_bt_prescaler #(.W(PRE_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div_field(cfg_q.pre), .tq_tick(tq_tick)
  );

  can_bt_segment #(.VOTES(VOTES)) i_seg (
    .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick),
    .ps1_len(ps1_len), .bit_len(bit_len),
    .at_sample(at_sample), .at_presample(at_presample), .at_end(at_end)
  );

  can_bt_vote #(.VOTES(VOTES)) i_vote (
    .clk(clk), .rst_n(rst_n), .run(run), .shift_en(at_presample),
    .multi(triple_eff), .rx(rx_in), .decided(decided)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_pulse <= 1'b0;
      bit_valid    <= 1'b0;
      bit_value    <= 1'b0;
      held_bit     <= 1'b0;
    end else begin
      sample_pulse <= at_sample;
      bit_valid    <= at_end;
      if (at_sample) held_bit  <= decided;
      if (at_end)    bit_value <= held_bit;
    end
  end
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker
  import can_bt_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sw_init,
  input logic    bit_valid,
  input logic    bit_value,
  input logic    sample_pulse,
  input bt_cfg_t cfg_q
);
  logic [1:0] sp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sp_seen <= '0;
    else if (sw_init || bit_valid)        sp_seen <= '0;
    else if (sample_pulse && sp_seen != 2'd3) sp_seen <= sp_seen + 2'd1;
  end

  // R10: end-of-bit strobe lasts one cycle
  p_valid_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R10: the delivered value moves only with the strobe
  p_value_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> $stable(bit_value));

  // R4: exactly one sample point inside each completed bit
  p_one_sample_per_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> (sp_seen == 2'd1));

  // R8: captured setup frozen outside the initialisation window
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_init |=> $stable(cfg_q));

  // R12: initialisation silences both strobes
  p_quiet_in_init_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_init |=> (!bit_valid && !sample_pulse));
endmodule

bind can_bit_sampler can_bt_checker i_chk (
  .clk(clk), .rst_n(rst_n), .sw_init(sw_init), .bit_valid(bit_valid),
  .bit_value(bit_value), .sample_pulse(sample_pulse), .cfg_q(cfg_q)
);

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_init = 1'b0;
  logic [5:0] cfg_prescale = '0;
  logic [3:0] cfg_ps1 = '0;
  logic [2:0] cfg_ps2 = 3'd1;
  logic       cfg_triple = 1'b0;
  logic       rx_in = 1'b0;
  logic       bit_valid, bit_value, sample_pulse, ps2_err;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R11";
  bit    comparing = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  can_bit_sampler i_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .sw_init(sw_init), .cfg_prescale(cfg_prescale),
    .cfg_ps1(cfg_ps1), .cfg_ps2(cfg_ps2), .cfg_triple(cfg_triple), .rx_in(rx_in),
    .bit_valid(bit_valid), .bit_value(bit_value), .sample_pulse(sample_pulse),
    .ps2_err(ps2_err)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  int m_pre, m_ps1, m_ps2, pc, q, p1, nb, ones;
  bit m_tr, trip, tick, e_valid, e_bit, e_sp, held;
  bit votes[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_ps1 = 0; m_ps2 = 1; m_tr = 0; pc = 0; q = 0;
      e_valid = 0; e_bit = 0; e_sp = 0; held = 0; votes.delete();
    end else begin
      e_valid = 0; e_sp = 0;
      if (sw_init) begin
        m_pre = int'(cfg_prescale); m_ps1 = int'(cfg_ps1);
        m_ps2 = int'(cfg_ps2); m_tr = cfg_triple;
        pc = 0; q = 0; votes.delete();
      end else begin
        trip = m_tr && (m_pre + 1 >= 4);
        p1   = m_ps1 + 1 + (trip ? 2 : 0);
        nb   = 1 + p1 + ((m_ps2 == 0) ? 2 : m_ps2 + 1);
        tick = (pc == m_pre);
        pc   = tick ? 0 : pc + 1;
        if (tick) begin
          if (trip && (q == p1 - 2 || q == p1 - 1)) votes.push_back(rx_in);
          if (q == p1) begin
            if (trip) begin
              ones = int'(rx_in);
              foreach (votes[k]) ones += int'(votes[k]);
              held = (ones >= 2);
            end else held = rx_in;
            votes.delete();
            e_sp = 1;
          end
          if (q == nb - 1) begin e_valid = 1; e_bit = held; q = 0; end
          else q++;
        end
      end
    end
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (comparing) begin
      check(cur_req, "sample_pulse", int'(sample_pulse), int'(e_sp));
      check(cur_req, "bit_valid", int'(bit_valid), int'(e_valid));
      check(cur_req, "bit_value", int'(bit_value), int'(e_bit));
      check(cur_req, "ps2_err (R9)", int'(ps2_err), (m_ps2 == 0) ? 1 : 0);
    end
  end

  // random receive line
  always @(negedge clk) rx_in <= 1'($urandom_range(0, 1));

  // bit period measurement
  int  cyc = 0, last_v = -1, exp_period = 0;
  bit  measuring = 0;
  always @(negedge clk) begin
    cyc++;
    if (measuring && bit_valid) begin
      if (last_v >= 0) check(cur_req, "bit period", cyc - last_v, exp_period);
      last_v = cyc;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic setup(int pre, int ps1, int ps2, bit tr);
    int len2;
    bit t;
    @(negedge clk);
    sw_init = 1; cfg_prescale = 6'(pre); cfg_ps1 = 4'(ps1);
    cfg_ps2 = 3'(ps2); cfg_triple = tr;
    repeat (2) @(negedge clk);
    sw_init = 0;
    t    = tr && (pre >= 3);
    len2 = (ps2 == 0) ? 2 : ps2 + 1;
    exp_period = (pre + 1) * (1 + ps1 + 1 + (t ? 2 : 0) + len2);
    last_v = -1;
    measuring = 1;
  endtask

  task automatic run_case(string req, int pre, int ps1, int ps2, bit tr, int cycles);
    cur_req = req;
    setup(pre, ps1, ps2, tr);
    repeat (cycles) @(negedge clk);
    measuring = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "bit_valid", int'(bit_valid), 0);
    check("R11", "bit_value", int'(bit_value), 0);
    check("R11", "sample_pulse", int'(sample_pulse), 0);
    check("R11", "ps2_err", int'(ps2_err), 0);
    rst_n = 1;
    comparing = 1;
    // R11: reset setup runs as 1 + 1 + 2 quanta of one clock
    cur_req = "R11"; exp_period = 4; last_v = -1; measuring = 1;
    repeat (40) @(negedge clk);
    measuring = 0;

    run_case("R1 R3 R4", 0, 3, 2, 0, 400);
    run_case("R1 R2 R10", 5, 7, 7, 0, 1500);
    run_case("R1 R2 R3", 63, 0, 1, 0, 1500);
    run_case("R5 R6", 3, 2, 3, 1, 1200);
    run_case("R5 R6 R10", 9, 15, 1, 1, 2500);
    run_case("R7", 2, 4, 3, 1, 800);
    run_case("R9", 1, 2, 0, 0, 600);
    check("R9", "ps2_err while code 0 held", int'(ps2_err), 1);

    // R8: setup changes outside the window are ignored
    cur_req = "R8";
    setup(4, 5, 2, 0);
    repeat (200) @(negedge clk);
    cfg_prescale = 6'd1; cfg_ps1 = 4'd0; cfg_ps2 = 3'd0; cfg_triple = 1;
    repeat (600) @(negedge clk);
    check("R8", "ps2_err after ignored change", int'(ps2_err), 0);
    measuring = 0;

    // R12: init window halts strobes, then a fresh bit starts
    cur_req = "R12";
    setup(2, 3, 3, 0);
    repeat (57) @(negedge clk);
    measuring = 0;
    sw_init = 1;
    @(negedge clk);
    repeat (6) begin
      @(negedge clk);
      check("R12", "bit_valid in init", int'(bit_valid), 0);
      check("R12", "sample_pulse in init", int'(sample_pulse), 0);
    end
    sw_init = 0;
    // first sample closes quantum 4 of 3 clocks, output one cycle later
    repeat (14) @(negedge clk);
    check("R12", "first sample after restart", int'(sample_pulse), 0);
    @(negedge clk);
    check("R12", "first sample after restart", int'(sample_pulse), 1);
    repeat (100) @(negedge clk);

    comparing = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule